// File: doc/BRIEF.md
# Phase-Accumulator Step Pulse Generator

This block turns a signed velocity command into a train of step pulses with a direction level by direct digital synthesis. On every update tick, the current command is added to a 16-bit phase accumulator. A carry out of the accumulator is one forward step, and a borrow out of it is one reverse step. No divider and no interval timer are involved, so the available output rates are evenly spaced fractions of the tick rate. This makes the block usable open loop.

The host may rewrite the command at any time, typically about once per millisecond while ticks arrive at 1 MHz or more. A new command takes effect on the next tick and never clears the accumulated phase, so slow motion keeps its sub-step progress across command changes. A fixed post-scaler can divide the overflow stream by a constant before it reaches the step output. The accumulator, extended by a signed count of overflows, is readable as a fine position. That position is the running sum of every command applied on a tick.

Top module: `stepgen_dds`

## Requirements
- R1: While reset is high and on the first cycle after it, `pos_o` is 0, `step_o` is 0 and `dir_o` is 0.
- R2: Each clock edge on which `tick_i` is high adds the held command to `pos_o`, modulo 2^32. The command is sign-extended and `pos_o` is read as a 32-bit two's-complement value. Edges without a tick leave `pos_o` unchanged.
- R3: A command written with `cmd_we_i` is used from the first tick after the write edge. When a write and a tick fall on the same edge, that tick uses the previously held command.
- R4: A carry out of the low 16 bits of `pos_o` (the accumulator) is a forward overflow and increments the upper 16 bits by one. A borrow is a reverse overflow and decrements them by one. At most one overflow occurs per tick.
- R5: With post-scaler ratio D, the net number of steps issued equals floor(T / D). Here T is the signed upper half of `pos_o` and a forward step counts +1. When D is 1, every overflow is a step.
- R6: `dir_o` is 0 for forward and 1 for reverse. It holds the direction of the step, and it is stable on the clock edge before `step_o` rises and while `step_o` is high.
- R7: `step_o` rises on the second clock edge after the tick edge that causes the step and stays high for exactly one clock. `tick_i` must not be high on two consecutive edges.
- R8: A command magnitude is limited to 2^16 − 1: the value −65536 acts as −65535.
- R9: A command change does not disturb the accumulator. Applying +v for n ticks and then −v for n ticks returns `pos_o` to its earlier value.
- R10: With a zero command, ticks issue no steps and leave `pos_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Update-rate enable; one accumulation per high edge |
| cmd_we_i | input | 1 | Load `cmd_i` into the command register |
| cmd_i | input | 17 | Signed velocity command, two's complement |
| step_o | output | 1 | One-clock step pulse |
| dir_o | output | 1 | Step direction, 1 = reverse |
| pos_o | output | 32 | Fine position: signed overflow count above the 16-bit accumulator |

## Verification
A host write and an update tick can land on the same edge. The bench provokes this deliberately: it writes a new command together with a tick. It then judges from `pos_o` that this tick added the old command and that the next tick added the new one. A reverse overflow can also follow close behind a forward one. This happens under random commands of both signs that change on most ticks, and the bench's edge monitor checks at every step rise that the direction level was already settled. Step totals are compared against the fine position for both a unit and a non-unit post-scaler.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

    localparam int ACC_W  = 16;
    localparam int TURN_W = 16;
    localparam int CMD_W  = ACC_W + 1;
    localparam int POS_W  = TURN_W + ACC_W;

    typedef struct packed {
        logic             rev;
        logic [ACC_W-1:0] mag;
    } vel_t;

    typedef struct packed {
        logic valid;
        logic rev;
    } step_evt_t;

    // Signed command to sign/magnitude, magnitude limited to ACC_W bits.
    function automatic vel_t cmd_to_vel(input logic signed [CMD_W-1:0] c);
        vel_t             v;
        logic [CMD_W-1:0] neg;
        v.rev = c[CMD_W-1];
        neg   = -c;
        if (!v.rev)
            v.mag = c[ACC_W-1:0];
        else if (neg[CMD_W-1])
            v.mag = '1;
        else
            v.mag = neg[ACC_W-1:0];
        return v;
    endfunction

endpackage

// File: rtl/vel_cmd_reg.sv
module vel_cmd_reg
    import stepgen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic signed [CMD_W-1:0] cmd,
    output vel_t                    vel
);

    localparam logic [CMD_W-1:0] MOST_NEG = {1'b1, {ACC_W{1'b0}}};

    vel_t vel_q;

    always_ff @(posedge clk) begin
        if (rst)
            vel_q <= '0;
        else if (we)
            vel_q <= cmd_to_vel(cmd);
    end

    assign vel = vel_q;

    AST_SAT_MAG: assert property (@(posedge clk) disable iff (rst)
        (we && cmd == MOST_NEG) |=> (vel_q.rev && vel_q.mag == '1)); // R8

endmodule

// File: rtl/phase_acc.sv
module phase_acc
    import stepgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  vel_t              vel,
    output logic [ACC_W-1:0]  acc,
    output logic [TURN_W-1:0] turns,
    output step_evt_t         evt
);

    logic [ACC_W-1:0]  acc_q;
    logic [TURN_W-1:0] turns_q;
    step_evt_t         evt_q;
    logic [ACC_W:0]    up_sum;
    logic [ACC_W:0]    dn_dif;

    always_comb begin
        up_sum = {1'b0, acc_q} + {1'b0, vel.mag};
        dn_dif = {1'b0, acc_q} - {1'b0, vel.mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            turns_q <= '0;
            evt_q   <= '0;
        end else begin
            evt_q.valid <= 1'b0;
            if (tick) begin
                if (vel.rev) begin
                    acc_q <= dn_dif[ACC_W-1:0];
                    if (dn_dif[ACC_W]) begin
                        turns_q <= turns_q - 1'b1;
                        evt_q   <= '{valid: 1'b1, rev: 1'b1};
                    end
                end else begin
                    acc_q <= up_sum[ACC_W-1:0];
                    if (up_sum[ACC_W]) begin
                        turns_q <= turns_q + 1'b1;
                        evt_q   <= '{valid: 1'b1, rev: 1'b0};
                    end
                end
            end
        end
    end

    assign acc   = acc_q;
    assign turns = turns_q;
    assign evt   = evt_q;

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt_q.valid && !evt_q.rev) |-> (acc_q < $past(acc_q))); // R4
    AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt_q.valid && evt_q.rev) |-> (acc_q > $past(acc_q))); // R4
    AST_QUIET_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !evt_q.valid); // R10

endmodule

// File: rtl/post_scaler.sv
module post_scaler
    import stepgen_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  step_evt_t in_evt,
    output step_evt_t out_evt
);

    generate
        if (DIV == 1) begin : g_pass
            assign out_evt = in_evt;
        end else begin : g_div
            localparam int RES_W = $clog2(DIV);
            localparam logic [RES_W-1:0] TOP = RES_W'(DIV - 1);

            logic [RES_W-1:0] res_q;

            always_ff @(posedge clk) begin
                if (rst)
                    res_q <= '0;
                else if (in_evt.valid) begin
                    if (!in_evt.rev)
                        res_q <= (res_q == TOP) ? '0 : res_q + 1'b1;
                    else
                        res_q <= (res_q == '0) ? TOP : res_q - 1'b1;
                end
            end

            always_comb begin
                out_evt.rev   = in_evt.rev;
                out_evt.valid = in_evt.valid &&
                    (in_evt.rev ? (res_q == '0) : (res_q == TOP));
            end

            AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
                res_q <= TOP); // R5
        end
    endgenerate

endmodule

// File: rtl/step_driver.sv
module step_driver
    import stepgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_evt_t evt,
    output logic      step,
    output logic      dir
);

    logic arm_q;
    logic step_q;
    logic dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            step_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            arm_q  <= evt.valid;
            step_q <= arm_q;
            if (evt.valid)
                dir_q <= evt.rev;
        end
    end

    assign step = step_q;
    assign dir  = dir_q;

endmodule

// File: rtl/stepgen_dds.sv
module stepgen_dds
    import stepgen_pkg::*;
#(
    parameter int PSC_DIV = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic                    cmd_we_i,
    input  logic signed [CMD_W-1:0] cmd_i,
    output logic                    step_o,
    output logic                    dir_o,
    output logic [POS_W-1:0]        pos_o
);

    vel_t              vel;
    logic [ACC_W-1:0]  acc;
    logic [TURN_W-1:0] turns;
    step_evt_t         raw_evt;
    step_evt_t         div_evt;

    vel_cmd_reg u_cmd (
        .clk (clk),
        .rst (rst),
        .we  (cmd_we_i),
        .cmd (cmd_i),
        .vel (vel)
    );

    phase_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_i),
        .vel   (vel),
        .acc   (acc),
        .turns (turns),
        .evt   (raw_evt)
    );

    post_scaler #(.DIV(PSC_DIV)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .in_evt  (raw_evt),
        .out_evt (div_evt)
    );

    step_driver u_drv (
        .clk  (clk),
        .rst  (rst),
        .evt  (div_evt),
        .step (step_o),
        .dir  (dir_o)
    );

    assign pos_o = {turns, acc};

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> !tick_i); // R7
    AST_DIR_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(step_o) |-> $stable(dir_o)); // R6
    AST_STEP_WIDTH: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o); // R7
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pos_o)); // R2

endmodule

// File: tb/tb_stepgen_dds.sv
module tb_stepgen_dds;

    localparam int D = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic               we = 1'b0;
    logic signed [16:0] cmd = '0;
    logic               step, dir, step1, dir1;
    logic [31:0]        pos, pos1;

    int n_run  = 0;
    int n_fail = 0;

    int          cmd_m = 0;
    logic [31:0] pos_m = '0;
    int          net0 = 0, net1 = 0;
    logic        ps0 = 0, pd0 = 0, ps1 = 0, pd1 = 0;

    always #5 clk = ~clk;

    stepgen_dds #(.PSC_DIV(D)) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .cmd_we_i(we), .cmd_i(cmd),
        .step_o(step), .dir_o(dir), .pos_o(pos));

    stepgen_dds #(.PSC_DIV(1)) dut_div1 (
        .clk(clk), .rst(rst), .tick_i(tick), .cmd_we_i(we), .cmd_i(cmd),
        .step_o(step1), .dir_o(dir1), .pos_o(pos1));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v < -65535) ? -65535 : v;
    endfunction

    function automatic int fdiv(input int a, input int d);
        return (a >= 0) ? a / d : -((-a + d - 1) / d);
    endfunction

    // step monitor: direction setup and net step counts
    always @(negedge clk) begin
        if (!rst) begin
            if (step && !ps0) begin
                chk(dir == pd0, "R6 dir setup (div)", dir, pd0);
                net0 += dir ? -1 : 1;
            end
            if (step1 && !ps1) begin
                chk(dir1 == pd1, "R6 dir setup (div1)", dir1, pd1);
                net1 += dir1 ? -1 : 1;
            end
        end
        ps0 = step; pd0 = dir; ps1 = step1; pd1 = dir1;
    end

    task automatic do_tick(input bit w, input int v);
        @(negedge clk);
        tick = 1'b1; we = w; cmd = 17'(v);
        @(negedge clk);
        tick = 1'b0; we = 1'b0;
        pos_m = pos_m + 32'(cmd_m);
        if (w) cmd_m = sat(v);
        chk(pos == pos_m, "R2 pos after tick", pos, pos_m);
        chk(pos1 == pos_m, "R2 pos after tick (div1)", pos1, pos_m);
    endtask

    task automatic write_cmd(input int v);
        @(negedge clk);
        we = 1'b1; cmd = 17'(v);
        @(negedge clk);
        we = 1'b0;
        cmd_m = sat(v);
        chk(pos == pos_m, "R2 no change without tick", pos, pos_m);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] p0;
        int          s0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(pos == 0 && step == 0 && dir == 0, "R1 reset state", pos, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pos == 0 && step == 0 && dir == 0, "R1 after reset", pos, 0);

        // R10: zero command
        s0 = net1;
        repeat (5) do_tick(1'b0, 0);
        drain();
        chk(net1 == s0 && pos == 0, "R10 zero command quiet", net1 - s0, 0);

        // R3: write coinciding with tick uses old command
        do_tick(1'b1, 100);
        chk(pos == 0, "R3 same-edge write uses old cmd", pos, 0);
        do_tick(1'b0, 0);
        chk(pos == 100, "R3 new cmd on next tick", pos, 100);

        // R8: most negative command saturates
        write_cmd(-65536);
        p0 = pos;
        do_tick(1'b0, 0);
        chk(pos == p0 - 32'd65535, "R8 saturated magnitude", pos, p0 - 32'd65535);

        // R7: step timing on the unit-ratio instance
        write_cmd(65535);
        if (pos_m[15:0] == 16'd0) do_tick(1'b1, 1);
        write_cmd(65535);
        drain();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        pos_m = pos_m + 32'd65535;
        chk(step1 == 1'b0, "R7 no step at tick edge", step1, 0);
        @(negedge clk);
        chk(step1 == 1'b0 && dir1 == 1'b0, "R7 step not yet, dir forward", step1, 0);
        @(negedge clk);
        chk(step1 == 1'b1, "R7 step two edges after tick", step1, 1);
        @(negedge clk);
        chk(step1 == 1'b0, "R7 one-clock width", step1, 0);

        // R9: phase retained across command changes
        p0 = pos_m;
        write_cmd(3000);
        repeat (12) do_tick(1'b0, 0);
        write_cmd(0);
        chk(pos == p0 + 32'd36000, "R9 phase held after cmd change", pos, p0 + 32'd36000);
        write_cmd(-3000);
        repeat (12) do_tick(1'b0, 0);
        chk(pos == p0, "R9 return to start", pos, p0);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int v;
            bit w;
            w = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 3))
                0: v = $urandom_range(0, 200) - 100;
                1: v = $urandom_range(0, 65535);
                2: v = -$urandom_range(0, 65536);
                default: v = (i % 2) ? 65535 : -65536;
            endcase
            if ($urandom_range(0, 4) == 0) write_cmd(v);
            else do_tick(w, v);
        end
        drain();
        chk(net1 == $signed(pos_m[31:16]), "R4 overflow count equals steps (div1)",
            net1, $signed(pos_m[31:16]));
        chk(net0 == fdiv($signed(pos_m[31:16]), D), "R5 post-scaled step count",
            net0, fdiv($signed(pos_m[31:16]), D));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule